// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This block is a byte-wide arithmetic stage for an accumulator pair made of a low byte (AL) and a high byte (AH). It performs binary addition and subtraction, with or without an incoming carry or borrow. It also performs two corrections that turn the binary byte left by an earlier add back into decimal form. The packed-decimal correction works on two BCD digits held in AL. The unpacked (ASCII) correction works on one digit in AL and carries into AH.

The corrections read the carry and auxiliary-carry flags produced by the preceding add, so software chains an add or add-with-carry with a correction, feeding the flag outputs back in as the flag inputs. Results and all six status flags are registered and appear one clock after the inputs are presented.

Top module: `dec_adjust_alu`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge clears every output to zero.
- R2: The outputs reflect the inputs presented before a rising edge and change only at that edge, a latency of one clock.
- R3: Operation code 0 adds the operand to AL and code 1 also adds `cf_i`; CF is the carry out of bit 7, AF the carry out of bit 3, and OF is set when two same-sign values give a result of the other sign.
- R4: Operation code 2 subtracts the operand from AL and code 3 also subtracts `cf_i`; CF is the borrow out of bit 7, AF the borrow into bit 4, and OF is set when operands of different sign give a result whose sign differs from AL.
- R5: Operation code 4 (packed-decimal correction) adds 06h when the low nibble of AL exceeds 9 or `af_i` is set, then setting AF (else clearing it), and adds 60h when the incoming AL exceeds 99h or `cf_i` is set, then setting CF (else clearing it).
- R6: Operation code 5 (unpacked correction), when the low nibble of AL exceeds 9 or `af_i` is set, adds 6 to AL, increments AH modulo 256 and sets both AF and CF, otherwise clears both; in every case bits 7:4 of the resulting AL are zero.
- R7: AH leaves the block unchanged for every operation code other than 5.
- R8: SF is bit 7 of the final AL, ZF is set when the final AL is zero, and PF is set when the final AL holds an even number of one bits.
- R9: OF is zero after operation codes 4 through 7.
- R10: Codes 6 and 7 are reserved: AL and AH pass through, and CF and AF copy `cf_i` and `af_i`.
- R11: An add-with-carry of two BCD bytes followed by a packed-decimal correction, fed the flags of the add, gives the two low decimal digits of the sum in AL and the hundreds carry in CF, for all operand pairs and both carry-in values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 3 | Operation code (0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 packed-decimal correction, 5 unpacked correction, 6-7 reserved) |
| acc_lo_i | input | 8 | Current AL |
| acc_hi_i | input | 8 | Current AH |
| operand_i | input | 8 | Second operand for add and subtract |
| cf_i | input | 1 | Current carry flag |
| af_i | input | 1 | Current auxiliary-carry flag |
| acc_lo_o | output | 8 | Updated AL |
| acc_hi_o | output | 8 | Updated AH |
| cf_o | output | 1 | Carry / borrow flag |
| af_o | output | 1 | Auxiliary-carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| pf_o | output | 1 | Even-parity flag |
| of_o | output | 1 | Signed-overflow flag |

## Verification
On every cycle the assertions watch the relations that hold whatever the operands: the cleared upper nibble and equal AF and CF after an unpacked correction, AH passing through for other codes, sticky CF in the packed correction, zero OF after corrections, and SF, ZF and PF matching the registered AL. The arithmetic values themselves, the correction thresholds, and the decimal correctness of an add followed by a correction can only be shown by the bench's scenarios, which include an exhaustive sweep of all BCD operand pairs with both carry-in values against a decimal model.

// File: rtl/dau_pkg.sv
// Package: shared constants and types for the decimal/ASCII adjust unit.
// Assumes a byte-wide datapath split into two nibbles.
package dau_pkg;
    localparam int DW  = 8;
    localparam int NIB = DW / 2;

    // Operation codes; values are part of the block's external contract.
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBB  = 3'd3,
        OP_DADJ = 3'd4,
        OP_AADJ = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef struct packed {
        logic cf;
        logic af;
        logic zf;
        logic sf;
        logic pf;
        logic of;
    } flags_t;
endpackage

// File: rtl/dau_binary.sv
// Module: binary add/subtract core with carry or borrow in.
// Produces the result, carry/borrow out, nibble carry/borrow and signed overflow.
// Assumes sub_en selects subtraction, in which case cin is a borrow.
module dau_binary
    import dau_pkg::*;
#(
    parameter int W = DW,
    parameter int H = NIB
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub_en,
    output logic [W-1:0] res,
    output logic         co,
    output logic         ac,
    output logic         ov
);
    logic [W:0]   wide;
    logic [W-1:0] diffbits;

    // Purpose: extended add or subtract so the top bit is carry or borrow.
    always_comb begin
        if (sub_en)
            wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        else
            wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end

    assign res      = wide[W-1:0];
    assign co       = wide[W];
    assign diffbits = a ^ b ^ res;
    assign ac       = diffbits[H];

    // Purpose: signed overflow from operand and result sign bits.
    always_comb begin
        if (sub_en)
            ov = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
        else
            ov = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
    end
endmodule

// File: rtl/dau_dec_fix.sv
// Module: packed-decimal correction of a byte holding two BCD digits.
// Assumes the byte and flags come from a preceding binary add.
module dau_dec_fix
    import dau_pkg::*;
#(
    parameter int W = DW,
    parameter int H = NIB
) (
    input  logic [W-1:0] val_i,
    input  logic         af_i,
    input  logic         cf_i,
    output logic [W-1:0] val_o,
    output logic         af_o,
    output logic         cf_o
);
    localparam logic [H-1:0] DIGIT_MAX = H'(9);
    localparam logic [W-1:0] BYTE_MAX  = {DIGIT_MAX, DIGIT_MAX};
    localparam logic [W-1:0] LO_STEP   = W'(6);
    localparam logic [W-1:0] HI_STEP   = LO_STEP << H;

    logic lo_fix, hi_fix;

    // Purpose: decide each digit correction from the incoming byte and flags.
    always_comb begin
        lo_fix = (val_i[H-1:0] > DIGIT_MAX) || af_i;
        hi_fix = (val_i > BYTE_MAX) || cf_i;
    end

    // Purpose: apply both corrections and report the resulting flags.
    always_comb begin
        val_o = val_i + (lo_fix ? LO_STEP : '0) + (hi_fix ? HI_STEP : '0);
        af_o  = lo_fix;
        cf_o  = hi_fix;
    end
endmodule

// File: rtl/dau_ascii_fix.sv
// Module: unpacked-digit correction of AL with carry into AH.
// Assumes AL holds one digit in its low nibble after a binary add.
module dau_ascii_fix
    import dau_pkg::*;
#(
    parameter int W = DW,
    parameter int H = NIB
) (
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    input  logic         af_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o,
    output logic         carry_o
);
    localparam logic [H-1:0] DIGIT_MAX = H'(9);
    localparam logic [W-1:0] STEP      = W'(6);

    logic         fix;
    logic [W-1:0] stepped;

    // Purpose: correct AL, clear its upper nibble and bump AH on a decimal carry.
    always_comb begin
        fix     = (lo_i[H-1:0] > DIGIT_MAX) || af_i;
        stepped = lo_i + (fix ? STEP : '0);
        lo_o    = {{(W-H){1'b0}}, stepped[H-1:0]};
        hi_o    = hi_i + {{(W-1){1'b0}}, fix};
        carry_o = fix;
    end
endmodule

// File: rtl/dau_status.sv
// Module: result-derived status bits (zero, sign, even parity) of a byte.
// Assumes parity covers the whole byte.
module dau_status
    import dau_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] val,
    output logic         zf,
    output logic         sf,
    output logic         pf
);
    // Purpose: derive the three result flags.
    always_comb begin
        zf = (val == '0);
        sf = val[W-1];
        pf = ~(^val);
    end
endmodule

// File: rtl/dec_adjust_alu.sv
// Module: top of the decimal/ASCII adjust unit. Selects binary add/subtract,
// packed-decimal or unpacked correction, and registers AL, AH and flags.
// Assumes flags are fed back by the surrounding logic between operations.
module dec_adjust_alu
    import dau_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] op_sel,
    input  logic [7:0] acc_lo_i,
    input  logic [7:0] acc_hi_i,
    input  logic [7:0] operand_i,
    input  logic       cf_i,
    input  logic       af_i,
    output logic [7:0] acc_lo_o,
    output logic [7:0] acc_hi_o,
    output logic       cf_o,
    output logic       af_o,
    output logic       zf_o,
    output logic       sf_o,
    output logic       pf_o,
    output logic       of_o
);
    logic [DW-1:0] bin_res;
    logic          bin_co, bin_ac, bin_ov, bin_sub, bin_cin;
    logic [DW-1:0] dec_res;
    logic          dec_af, dec_cf;
    logic [DW-1:0] asc_lo, asc_hi;
    logic          asc_carry;
    logic [DW-1:0] nxt_lo, nxt_hi;
    logic          nxt_cf, nxt_af, nxt_of;
    logic          st_zf, st_sf, st_pf;
    flags_t        flg_q;
    logic [DW-1:0] lo_q, hi_q;

    // Purpose: pick subtract mode and whether the incoming carry takes part.
    always_comb begin
        bin_sub = (op_sel == OP_SUB) || (op_sel == OP_SBB);
        bin_cin = ((op_sel == OP_ADC) || (op_sel == OP_SBB)) ? cf_i : 1'b0;
    end

    dau_binary u_bin (
        .a      (acc_lo_i),
        .b      (operand_i),
        .cin    (bin_cin),
        .sub_en (bin_sub),
        .res    (bin_res),
        .co     (bin_co),
        .ac     (bin_ac),
        .ov     (bin_ov)
    );

    dau_dec_fix u_dec (
        .val_i (acc_lo_i),
        .af_i  (af_i),
        .cf_i  (cf_i),
        .val_o (dec_res),
        .af_o  (dec_af),
        .cf_o  (dec_cf)
    );

    dau_ascii_fix u_asc (
        .lo_i    (acc_lo_i),
        .hi_i    (acc_hi_i),
        .af_i    (af_i),
        .lo_o    (asc_lo),
        .hi_o    (asc_hi),
        .carry_o (asc_carry)
    );

    // Purpose: select the next accumulator pair and arithmetic flags by opcode.
    always_comb begin
        nxt_lo = acc_lo_i;
        nxt_hi = acc_hi_i;
        nxt_cf = cf_i;
        nxt_af = af_i;
        nxt_of = 1'b0;
        case (op_sel)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                nxt_lo = bin_res;
                nxt_cf = bin_co;
                nxt_af = bin_ac;
                nxt_of = bin_ov;
            end
            OP_DADJ: begin
                nxt_lo = dec_res;
                nxt_cf = dec_cf;
                nxt_af = dec_af;
            end
            OP_AADJ: begin
                nxt_lo = asc_lo;
                nxt_hi = asc_hi;
                nxt_cf = asc_carry;
                nxt_af = asc_carry;
            end
            default: begin
            end
        endcase
    end

    dau_status u_st (
        .val (nxt_lo),
        .zf  (st_zf),
        .sf  (st_sf),
        .pf  (st_pf)
    );

    // Purpose: output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            flg_q <= '0;
        end else begin
            lo_q     <= nxt_lo;
            hi_q     <= nxt_hi;
            flg_q.cf <= nxt_cf;
            flg_q.af <= nxt_af;
            flg_q.zf <= st_zf;
            flg_q.sf <= st_sf;
            flg_q.pf <= st_pf;
            flg_q.of <= nxt_of;
        end
    end

    assign acc_lo_o = lo_q;
    assign acc_hi_o = hi_q;
    assign cf_o     = flg_q.cf;
    assign af_o     = flg_q.af;
    assign zf_o     = flg_q.zf;
    assign sf_o     = flg_q.sf;
    assign pf_o     = flg_q.pf;
    assign of_o     = flg_q.of;

    AST_ASCII_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == OP_AADJ) |-> (acc_lo_o[7:4] == 4'h0)); // R6

    AST_ASCII_FLAGS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == OP_AADJ) |-> (af_o == cf_o)); // R6

    AST_HIGH_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) != OP_AADJ) |-> (acc_hi_o == $past(acc_hi_i))); // R7

    AST_DEC_CARRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == OP_DADJ && $past(cf_i)) |-> cf_o); // R5

    AST_ADJUST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel[2])) |-> !of_o); // R9

    AST_RESULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (zf_o == (acc_lo_o == 8'h00)) && (sf_o == acc_lo_o[7])
                         && (pf_o == ~(^acc_lo_o))); // R8
endmodule

// File: tb/dec_adjust_alu_tb.sv
`timescale 1ns/1ps
module dec_adjust_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel = '0;
    logic [7:0] acc_lo_i = '0, acc_hi_i = '0, operand_i = '0;
    logic       cf_i = 1'b0, af_i = 1'b0;
    logic [7:0] acc_lo_o, acc_hi_o;
    logic       cf_o, af_o, zf_o, sf_o, pf_o, of_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dec_adjust_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel),
        .acc_lo_i(acc_lo_i), .acc_hi_i(acc_hi_i), .operand_i(operand_i),
        .cf_i(cf_i), .af_i(af_i),
        .acc_lo_o(acc_lo_o), .acc_hi_o(acc_hi_o),
        .cf_o(cf_o), .af_o(af_o), .zf_o(zf_o), .sf_o(sf_o), .pf_o(pf_o), .of_o(of_o)
    );

    // Vector: op(3) al(8) ah(8) operand(8) cf(1) af(1) exp_al(8) exp_ah(8)
    // exp_flags(6) ordered {cf,af,zf,sf,pf,of}
    localparam int NV = 21;
    localparam logic [50:0] VEC [NV] = '{
        {3'd0, 8'h34, 8'h00, 8'h99, 1'b0, 1'b0, 8'hCD, 8'h00, 6'b000100},
        {3'd4, 8'hCD, 8'h00, 8'h00, 1'b0, 1'b0, 8'h33, 8'h00, 6'b110010},
        {3'd1, 8'h30, 8'h00, 8'h12, 1'b1, 1'b0, 8'h43, 8'h00, 6'b000000},
        {3'd4, 8'h43, 8'h00, 8'h00, 1'b0, 1'b0, 8'h43, 8'h00, 6'b000000},
        {3'd0, 8'h31, 8'h00, 8'h39, 1'b0, 1'b0, 8'h6A, 8'h00, 6'b000010},
        {3'd5, 8'h6A, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h01, 6'b111010},
        {3'd2, 8'h10, 8'h00, 8'h01, 1'b1, 1'b0, 8'h0F, 8'h00, 6'b010010},
        {3'd3, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 8'h00, 6'b110110},
        {3'd0, 8'h7F, 8'h00, 8'h01, 1'b0, 1'b0, 8'h80, 8'h00, 6'b010101},
        {3'd2, 8'h80, 8'h00, 8'h01, 1'b0, 1'b0, 8'h7F, 8'h00, 6'b010001},
        {3'd0, 8'hFF, 8'h00, 8'h01, 1'b0, 1'b0, 8'h00, 8'h00, 6'b111010},
        {3'd4, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 8'h66, 8'h00, 6'b110010},
        {3'd5, 8'h35, 8'h07, 8'h00, 1'b0, 1'b0, 8'h05, 8'h07, 6'b000010},
        {3'd5, 8'h09, 8'hFF, 8'h00, 1'b0, 1'b1, 8'h0F, 8'h00, 6'b110010},
        {3'd3, 8'h05, 8'h00, 8'h03, 1'b0, 1'b0, 8'h02, 8'h00, 6'b000000},
        {3'd4, 8'h9A, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 6'b111010},
        {3'd7, 8'h80, 8'h5A, 8'h33, 1'b1, 1'b0, 8'h80, 8'h5A, 6'b100100},
        {3'd0, 8'h01, 8'hC3, 8'h02, 1'b0, 1'b0, 8'h03, 8'hC3, 6'b000010},
        {3'd2, 8'h00, 8'hA5, 8'h01, 1'b0, 1'b0, 8'hFF, 8'hA5, 6'b110110},
        {3'd4, 8'h12, 8'h00, 8'h00, 1'b0, 1'b1, 8'h18, 8'h00, 6'b010010},
        {3'd4, 8'hA2, 8'h00, 8'h00, 1'b0, 1'b0, 8'h02, 8'h00, 6'b100000}
    };

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            3'd4:       return "R5";
            3'd5:       return "R6";
            default:    return "R10";
        endcase
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge; results are registered at the next rising
    // edge and sampled at the falling edge after it.
    task automatic apply(input logic [2:0] op, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] opd, input logic c, input logic a);
        @(negedge clk);
        op_sel = op; acc_lo_i = lo; acc_hi_i = hi; operand_i = opd; cf_i = c; af_i = a;
        @(negedge clk);
    endtask

    function automatic logic [5:0] flags_now();
        return {cf_o, af_o, zf_o, sf_o, pf_o, of_o};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset clears outputs even with active stimulus
        op_sel = 3'd0; acc_lo_i = 8'hFF; acc_hi_i = 8'h77; operand_i = 8'h01;
        repeat (3) @(negedge clk);
        check("R1 reset lo/hi", {16'h0, acc_lo_o, acc_hi_o}, 32'h0);
        check("R1 reset flags", {26'h0, flags_now()}, 32'h0);
        rst_n = 1'b1;

        // Table of directed vectors (R3 R4 R5 R6 R7 R8 R9 R10)
        for (int i = 0; i < NV; i++) begin
            logic [50:0] v;
            v = VEC[i];
            apply(v[50:48], v[47:40], v[39:32], v[31:24], v[23], v[22]);
            check($sformatf("%s vec%0d AL (R8)", req_of(v[50:48]), i),
                  {24'h0, acc_lo_o}, {24'h0, v[21:14]});
            check($sformatf("%s vec%0d AH (R7)", req_of(v[50:48]), i),
                  {24'h0, acc_hi_o}, {24'h0, v[13:6]});
            check($sformatf("%s vec%0d flags (R8 R9)", req_of(v[50:48]), i),
                  {26'h0, flags_now()}, {26'h0, v[5:0]});
        end

        // R2: outputs hold until the next rising edge, then update
        apply(3'd0, 8'h11, 8'h00, 8'h22, 1'b0, 1'b0);
        @(negedge clk);
        op_sel = 3'd0; acc_lo_i = 8'h40; operand_i = 8'h05;
        #1;
        check("R2 hold before edge", {24'h0, acc_lo_o}, 32'h33);
        @(negedge clk);
        check("R2 update after edge", {24'h0, acc_lo_o}, 32'h45);

        // R6: every unpacked correction leaves AL upper nibble clear
        for (int x = 0; x < 256; x += 17) begin
            apply(3'd5, 8'(x), 8'h10, 8'h00, 1'b0, 1'b0);
            check("R6 upper nibble clear", {28'h0, acc_lo_o[7:4]}, 32'h0);
        end

        // R6: ASCII digit sums corrected into AH:AL
        for (int a = 0; a < 10; a++) begin
            for (int b = 0; b < 10; b++) begin
                logic [7:0] r;
                logic       ra;
                apply(3'd0, 8'h30 + 8'(a), 8'h00, 8'h30 + 8'(b), 1'b0, 1'b0);
                r = acc_lo_o; ra = af_o;
                apply(3'd5, r, 8'h00, 8'h00, 1'b0, ra);
                check($sformatf("R6 ascii %0d+%0d", a, b),
                      {16'h0, acc_hi_o, acc_lo_o},
                      {16'h0, 8'((a + b) / 10), 8'((a + b) % 10)});
            end
        end

        // R11: exhaustive packed-decimal sums against a decimal model
        for (int a = 0; a < 100; a++) begin
            for (int b = 0; b < 100; b++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [7:0] r;
                    logic       rc, ra;
                    int         s;
                    s = a + b + c;
                    apply(3'd1, to_bcd(a), 8'h00, to_bcd(b), 1'(c), 1'b0);
                    r = acc_lo_o; rc = cf_o; ra = af_o;
                    apply(3'd4, r, 8'h00, 8'h00, rc, ra);
                    check($sformatf("R11 bcd %0d+%0d+%0d", a, b, c),
                          {23'h0, cf_o, acc_lo_o},
                          {23'h0, 1'(s >= 100), to_bcd(s % 100)});
                end
            end
        end

        // R1: reset asserted mid-run clears results again
        apply(3'd0, 8'hF0, 8'h44, 8'h20, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", {8'h0, acc_lo_o, acc_hi_o, 2'b0, flags_now()}, 32'h0);
        rst_n = 1'b1;

        finish_run();
    end
endmodule